// File: doc/BRIEF.md
# Switch-Driven Register File Test Adapter

This block sits between a board's slide switches and push-keys and a 32-entry, 32-bit register file. Its job is to let a person exercise that register file by hand. Ten switches give the two read addresses directly. The same switches also feed a byte lane and a byte value. Two keys pick which 16-bit half of which read result is shown on four hex digits. A third key puts the switch byte into a 32-bit holding word. A fourth key writes the holding word into the register chosen by the low five switches.

The keys are active-low and asynchronous to the clock. Each key passes through a two-stage synchroniser. The load key and the write key are then reduced to a one-cycle pulse on the press edge, so one press causes exactly one load or one write, however long the key is held. The two display keys are used as synchronised levels.

For each digit the block outputs the raw 4-bit nibble and an active-low seven-segment pattern. The register file itself sits outside the block: it receives the addresses, write data and write enable, and it returns the two read words.

Top module: `regfile_test_adapter`

## Requirements
- R1: `rd_addr_a_o` equals `sw_i[9:5]` and `rd_addr_b_o` equals `sw_i[4:0]`, combinationally, in the same cycle.
- R2: The view code is {key1 pressed, key0 pressed}, where pressed means `key_n_i` is low. Code 0 shows `rd_data_a_i[15:0]`, 1 shows `rd_data_a_i[31:16]`, 2 shows `rd_data_b_i[15:0]` and 3 shows `rd_data_b_i[31:16]` on `digit_nib_o`, whose bits [3:0] are the least significant digit. A change of key level takes effect after two clock edges.
- R3: A press of key2 writes `sw_i[7:0]` into byte lane `sw_i[9:8]` of the holding word and leaves the other three lanes unchanged. Lane 0 is bits [7:0]. The holding word is presented on `wr_data_o` and changes on the third rising edge after the key falls.
- R4: A press of key3 raises `wr_en_o` for exactly one clock cycle, starting after the second rising edge after the key falls. In that cycle `wr_addr_o` equals `sw_i[4:0]` and `wr_data_o` carries the holding word.
- R5: Holding a key down for any time produces only one load or one write. Releasing a key produces none.
- R6: While `rst_n` is low, the holding word is cleared to zero and `wr_en_o` stays low.
- R7: Digit i's pattern is `seg_n_o[7i+6:7i]`, with bits {g,f,e,d,c,b,a} and a segment lit when its bit is 0. The 16 hex codes are: 0=40, 1=79, 2=24, 3=30, 4=19, 5=12, 6=02, 7=78, 8=00, 9=10, A=08, b=03, C=46, d=21, E=06, F=0E.
- R8: When key2 and key3 are pressed in the same cycle, the write carries the holding word from before that load. The load then appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_i | input | 10 | Slide switches |
| key_n_i | input | 4 | Push-keys, active-low |
| rd_data_a_i | input | 32 | Read result of port A from the register file |
| rd_data_b_i | input | 32 | Read result of port B from the register file |
| rd_addr_a_o | output | 5 | Read address of port A |
| rd_addr_b_o | output | 5 | Read address of port B |
| wr_addr_o | output | 5 | Write address |
| wr_data_o | output | 32 | Holding word, used as write data |
| wr_en_o | output | 1 | One-cycle write strobe |
| digit_nib_o | output | 16 | Four displayed nibbles |
| seg_n_o | output | 28 | Four active-low seven-segment patterns |

## Verification
- The read addresses and the displayed data are combinational, so they are sampled one time step after the switches or read words are driven.
- A view-key change needs two rising edges, so the bench waits three falling edges before it samples the digits.
- After a key3 fall, the bench expects `wr_en_o` low at the first falling edge, high at the second, and low again from the third onward.
- After a key2 fall, the holding word is checked at the third falling edge. While the key is held, the bench counts strobes and changes of the holding word and compares both counts with one.

// File: rtl/adapter_pkg.sv
// Package: shared constants and types for the register file test adapter.
// Assumes a register file with 2**ADDR_W entries of WORD_W bits.
package adapter_pkg;

    localparam int ADDR_W  = 5;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int SEG_W   = 7;
    localparam int NUM_KEY = 4;

    // Index of each key in the key bus.
    localparam int KEY_VIEW0 = 0;
    localparam int KEY_VIEW1 = 1;
    localparam int KEY_LOAD  = 2;
    localparam int KEY_WRITE = 3;

    // Which half of which read port is displayed.
    typedef enum logic [1:0] {
        VIEW_A_LO = 2'b00,
        VIEW_A_HI = 2'b01,
        VIEW_B_LO = 2'b10,
        VIEW_B_HI = 2'b11
    } view_code_t;

endpackage

// File: rtl/key_edge_pulse.sv
// Module: key_edge_pulse
// Synchronises one active-low key and reports its pressed level.
// Also gives a one-cycle pulse on each press (a fall of the key).
// Assumes the key is asynchronous to clk and already debounced.
// At reset the chain holds the released state.
module key_edge_pulse #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_n,
    output logic pressed,
    output logic press_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the raw key level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], key_n};
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else begin
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Pressed is the inverted synchronised level; the pulse marks a falling edge.
    always_comb begin
        pressed     = ~sync_q[SYNC_STAGES-1];
        press_pulse = last_q & ~sync_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/word_assembler.sv
// Module: word_assembler
// Holds a word that is built one byte lane at a time.
// On load, the chosen lane takes the new byte and the other lanes keep their value.
// Assumes WORD_W is a whole multiple of BYTE_W. Clears to zero on reset.
module word_assembler #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] lane_sel,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        logic              hit;

        // Decode whether this lane is the load target.
        always_comb begin
            hit = load && (lane_sel == LANE_W'(g));
        end

        // Store the lane byte; only the selected lane updates.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (hit) begin
                lane_q <= byte_in;
            end
        end

        assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/view_select.sv
// Module: view_select
// Picks one half of one of two read words for display.
// The code follows adapter_pkg::view_code_t. Purely combinational.
module view_select
    import adapter_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int HALF_W = WORD_W / 2
) (
    input  view_code_t        code,
    input  logic [WORD_W-1:0] data_a,
    input  logic [WORD_W-1:0] data_b,
    output logic [HALF_W-1:0] view_o
);

    // Route the selected half-word to the display.
    always_comb begin
        unique case (code)
            VIEW_A_LO: view_o = data_a[HALF_W-1:0];
            VIEW_A_HI: view_o = data_a[WORD_W-1:HALF_W];
            VIEW_B_LO: view_o = data_b[HALF_W-1:0];
            VIEW_B_HI: view_o = data_b[WORD_W-1:HALF_W];
            default:   view_o = '0;
        endcase
    end

endmodule

// File: rtl/hex_to_seg.sv
// Module: hex_to_seg
// Turns one hex nibble into an active-low seven-segment pattern.
// Bit order is {g,f,e,d,c,b,a}, and a 0 lights the segment. Combinational.
module hex_to_seg (
    input  logic [3:0] nib,
    output logic [6:0] seg_n
);

    // Glyph lookup for the digits 0-9 and the letters A, b, C, d, E, F.
    always_comb begin
        unique case (nib)
            4'h0: seg_n = 7'h40;
            4'h1: seg_n = 7'h79;
            4'h2: seg_n = 7'h24;
            4'h3: seg_n = 7'h30;
            4'h4: seg_n = 7'h19;
            4'h5: seg_n = 7'h12;
            4'h6: seg_n = 7'h02;
            4'h7: seg_n = 7'h78;
            4'h8: seg_n = 7'h00;
            4'h9: seg_n = 7'h10;
            4'hA: seg_n = 7'h08;
            4'hB: seg_n = 7'h03;
            4'hC: seg_n = 7'h46;
            4'hD: seg_n = 7'h21;
            4'hE: seg_n = 7'h06;
            4'hF: seg_n = 7'h0E;
            default: seg_n = 7'h7F;
        endcase
    end

endmodule

// File: rtl/regfile_test_adapter.sv
// Module: regfile_test_adapter (top)
// Lets switches and keys drive a register file and shows a read result on hex digits.
// sw[9:5] and sw[4:0] are the read addresses. sw[9:8] and sw[7:0] are the lane and byte for a load.
// sw[4:0] is also the write address. Key0 and key1 pick the view, key2 loads a byte,
// and key3 writes the holding word.
// Assumes the keys are active-low and debounced, and that the register file reads combinationally.
module regfile_test_adapter
    import adapter_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*ADDR_W-1:0]     sw_i,
    input  logic [NUM_KEY-1:0]      key_n_i,
    input  logic [WORD_W-1:0]       rd_data_a_i,
    input  logic [WORD_W-1:0]       rd_data_b_i,
    output logic [ADDR_W-1:0]       rd_addr_a_o,
    output logic [ADDR_W-1:0]       rd_addr_b_o,
    output logic [ADDR_W-1:0]       wr_addr_o,
    output logic [WORD_W-1:0]       wr_data_o,
    output logic                    wr_en_o,
    output logic [WORD_W/2-1:0]     digit_nib_o,
    output logic [(WORD_W/8)*SEG_W-1:0] seg_n_o
);

    localparam int HALF_W = WORD_W / 2;
    localparam int DIGITS = HALF_W / NIB_W;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    logic [NUM_KEY-1:0] key_level;
    logic [NUM_KEY-1:0] key_pulse;
    logic               byte_load;
    view_code_t         view_code;
    logic [HALF_W-1:0]  view_half;

    // One synchroniser and edge detector per key.
    for (genvar k = 0; k < NUM_KEY; k++) begin : g_key
        key_edge_pulse #(.SYNC_STAGES(SYNC_STAGES)) u_key (
            .clk        (clk),
            .rst_n      (rst_n),
            .key_n      (key_n_i[k]),
            .pressed    (key_level[k]),
            .press_pulse(key_pulse[k])
        );
    end

    // Switch-to-address mapping and the key-derived controls.
    always_comb begin
        rd_addr_a_o = sw_i[2*ADDR_W-1:ADDR_W];
        rd_addr_b_o = sw_i[ADDR_W-1:0];
        wr_addr_o   = sw_i[ADDR_W-1:0];
        byte_load   = key_pulse[KEY_LOAD];
        wr_en_o     = key_pulse[KEY_WRITE];
        view_code   = view_code_t'({key_level[KEY_VIEW1], key_level[KEY_VIEW0]});
    end

    // Holding word assembled from switch bytes.
    word_assembler #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (byte_load),
        .lane_sel(sw_i[BYTE_W +: LANE_W]),
        .byte_in (sw_i[BYTE_W-1:0]),
        .word_o  (wr_data_o)
    );

    // Display half-word selection.
    view_select #(.WORD_W(WORD_W)) u_view (
        .code  (view_code),
        .data_a(rd_data_a_i),
        .data_b(rd_data_b_i),
        .view_o(view_half)
    );

    assign digit_nib_o = view_half;

    // One segment decoder per digit.
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        hex_to_seg u_seg (
            .nib  (view_half[d*NIB_W +: NIB_W]),
            .seg_n(seg_n_o[d*SEG_W +: SEG_W])
        );
    end

endmodule

// File: rtl/adapter_chk.sv
// Module: adapter_chk
// Checker bound to regfile_test_adapter. It relates the key inputs to the
// write strobe and the loads to changes in the holding word.
module adapter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  key_n_i,
    input logic        wr_en_o,
    input logic [31:0] wr_data_o,
    input logic        byte_load
);

    logic [31:0] prev_word_q;
    logic [3:0]  lane_diff;

    // Keep last cycle's holding word to see which lanes changed.
    always_ff @(posedge clk) begin
        prev_word_q <= wr_data_o;
    end

    // Flag every byte lane that differs from last cycle.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            lane_diff[i] = (wr_data_o[i*8 +: 8] != prev_word_q[i*8 +: 8]);
        end
    end

    // R4
    wr_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R4
    wr_strobe_from_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(key_n_i[3], 2) == 1'b0));

    // R5
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_load |=> !byte_load);

    // R3
    word_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_data_o) |-> $past(byte_load));

    // R3
    word_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_load |=> ($countones(lane_diff) <= 1));

    // R6
    word_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (wr_data_o == 32'h0));

endmodule

bind regfile_test_adapter adapter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_n_i  (key_n_i),
    .wr_en_o  (wr_en_o),
    .wr_data_o(wr_data_o),
    .byte_load(byte_load)
);

// File: tb/sim_regfile_test_adapter.sv
// Directed bench for regfile_test_adapter: one task per scenario.
module sim_regfile_test_adapter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  sw = '0;
    logic [3:0]  key_n = 4'hF;
    logic [31:0] rda = '0;
    logic [31:0] rdb = '0;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] wr_data;
    logic        wr_en;
    logic [15:0] digit_nib;
    logic [27:0] seg_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] exp_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regfile_test_adapter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_i       (sw),
        .key_n_i    (key_n),
        .rd_data_a_i(rda),
        .rd_data_b_i(rdb),
        .rd_addr_a_o(rd_addr_a),
        .rd_addr_b_o(rd_addr_b),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .wr_en_o    (wr_en),
        .digit_nib_o(digit_nib),
        .seg_n_o    (seg_n)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] n);
        case (n)
            4'h0: return 7'h40;  4'h1: return 7'h79;  4'h2: return 7'h24;  4'h3: return 7'h30;
            4'h4: return 7'h19;  4'h5: return 7'h12;  4'h6: return 7'h02;  4'h7: return 7'h78;
            4'h8: return 7'h00;  4'h9: return 7'h10;  4'hA: return 7'h08;  4'hB: return 7'h03;
            4'hC: return 7'h46;  4'hD: return 7'h21;  4'hE: return 7'h06;  default: return 7'h0E;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_view(input logic [1:0] code);
        key_n[1] = ~code[1];
        key_n[0] = ~code[0];
        idle(3);
    endtask

    // R6: state after reset.
    task automatic t_reset();
        rda = 32'h1357_9BDF;
        #1;
        chk("R6 wr_en after reset", {31'b0, wr_en}, 32'h0);
        chk("R6 word after reset", wr_data, 32'h0);
        chk("R2 view 0 after reset", {16'b0, digit_nib}, 32'h9BDF);
    endtask

    // R1: read addresses follow the switches.
    task automatic t_read_addr();
        logic [9:0] pats [4] = '{10'h3E0, 10'h01F, 10'h2A5, 10'h15A};
        foreach (pats[i]) begin
            sw = pats[i];
            #1;
            chk("R1 rd_addr_a", {27'b0, rd_addr_a}, {27'b0, pats[i][9:5]});
            chk("R1 rd_addr_b", {27'b0, rd_addr_b}, {27'b0, pats[i][4:0]});
        end
        idle(1);
    endtask

    // R2: four view codes.
    task automatic t_view();
        rda = 32'hA1B2_C3D4;
        rdb = 32'h5E6F_7089;
        set_view(2'd0); chk("R2 code0", {16'b0, digit_nib}, 32'hC3D4);
        set_view(2'd1); chk("R2 code1", {16'b0, digit_nib}, 32'hA1B2);
        set_view(2'd2); chk("R2 code2", {16'b0, digit_nib}, 32'h7089);
        set_view(2'd3); chk("R2 code3", {16'b0, digit_nib}, 32'h5E6F);
        key_n[1] = 1'b0; key_n[0] = 1'b1;
        idle(1);
        chk("R2 latency not yet", {16'b0, digit_nib}, 32'h5E6F);
        idle(2);
        chk("R2 latency done", {16'b0, digit_nib}, 32'h7089);
        set_view(2'd0);
    endtask

    // R7: all sixteen segment patterns.
    task automatic t_seg();
        logic [31:0] words [2] = '{32'h7654_3210, 32'hFEDC_BA98};
        foreach (words[w]) begin
            rda = words[w];
            for (int h = 0; h < 2; h++) begin
                set_view(h[1:0]);
                for (int d = 0; d < 4; d++) begin
                    chk("R7 segment pattern", {25'b0, seg_n[d*7 +: 7]},
                        {25'b0, ref_seg(words[w][h*16 + d*4 +: 4])});
                end
            end
        end
        set_view(2'd0);
    endtask

    // R3: load one byte lane.
    task automatic load_byte(input logic [1:0] lane, input logic [7:0] val);
        sw = {lane, val};
        key_n[2] = 1'b0;
        idle(2);
        chk("R3 word before update", wr_data, exp_word);
        idle(1);
        exp_word[lane*8 +: 8] = val;
        chk("R3 byte lane load", wr_data, exp_word);
        key_n[2] = 1'b1;
        idle(3);
    endtask

    task automatic t_load();
        load_byte(2'd0, 8'h11);
        load_byte(2'd3, 8'hC4);
        load_byte(2'd1, 8'h2E);
        load_byte(2'd2, 8'h9B);
        load_byte(2'd0, 8'hF0);
    endtask

    // R4 and R5: a write strobe from a long press.
    task automatic t_write(input logic [4:0] addr);
        int highs;
        sw = {5'b0, addr};
        key_n[3] = 1'b0;
        idle(1);
        chk("R4 no strobe after one edge", {31'b0, wr_en}, 32'h0);
        idle(1);
        chk("R4 strobe", {31'b0, wr_en}, 32'h1);
        chk("R4 write address", {27'b0, wr_addr}, {27'b0, addr});
        chk("R4 write data", wr_data, exp_word);
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            idle(1);
            if (wr_en) highs++;
        end
        chk("R5 no extra strobe while held", highs, 0);
        key_n[3] = 1'b1;
        highs = 0;
        for (int i = 0; i < 5; i++) begin
            idle(1);
            if (wr_en) highs++;
        end
        chk("R5 no strobe on release", highs, 0);
    endtask

    // R5: a held load key with changing switches loads once.
    task automatic t_hold_load();
        sw = {2'd1, 8'h77};
        key_n[2] = 1'b0;
        idle(3);
        exp_word[15:8] = 8'h77;
        chk("R5 first load", wr_data, exp_word);
        sw = {2'd2, 8'h33};
        idle(6);
        chk("R5 held key no reload", wr_data, exp_word);
        key_n[2] = 1'b1;
        idle(4);
        chk("R5 release no reload", wr_data, exp_word);
    endtask

    // R8: load and write pressed together.
    task automatic t_simul();
        logic [31:0] old_word;
        old_word = exp_word;
        sw = {2'd0, 8'h5A};
        key_n[3:2] = 2'b00;
        idle(2);
        chk("R8 strobe", {31'b0, wr_en}, 32'h1);
        chk("R8 write uses old word", wr_data, old_word);
        idle(1);
        exp_word[7:0] = 8'h5A;
        chk("R8 load follows", wr_data, exp_word);
        key_n[3:2] = 2'b11;
        idle(4);
    endtask

    // R6: a reset in mid-run clears the word.
    task automatic t_reset_mid();
        rst_n = 1'b0;
        idle(2);
        chk("R6 word cleared in reset", wr_data, 32'h0);
        chk("R6 no strobe in reset", {31'b0, wr_en}, 32'h0);
        rst_n = 1'b1;
        exp_word = '0;
        idle(3);
        chk("R6 word zero after reset", wr_data, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_read_addr();
        t_view();
        t_seg();
        t_load();
        t_write(5'd19);
        t_hold_load();
        t_write(5'd0);
        t_simul();
        t_reset_mid();
        load_byte(2'd2, 8'hAB);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule